// File: doc/BRIEF.md
# Transparent Clock Residence Time Corrector

This block is the timing core of an end-to-end transparent clock port pair inside a forwarding device. When a precision-time event message crosses the ingress boundary, the block records the current value of a free-running nanosecond timebase. It files that time under the message's packet tag. When the same tag appears at the egress boundary, the block measures how long the message stayed in the device. It adds a programmable fixed latency calibration term to that time. The sum is added to the message's 64-bit correction field, and the updated field is returned to the frame rewriter.

Queueing delay changes from packet to packet, so the block measures each packet on its own and never uses a constant. The correction field is a signed value in nanoseconds scaled by 2^16. Residence time is therefore shifted left by 16 bits before it is added. The addition saturates at the largest positive value instead of wrapping.

If an egress strobe carries a tag with no pending ingress time, the correction field passes through unchanged and an error flag is raised with the result.

Top module: `tc_residence_corrector`

## Requirements
- R1: An ingress strobe (`ing_valid`=1) stores the value of `time_ns` in that cycle as the pending ingress time for tag `ing_tag`.
- R2: Residence time is the `time_ns` value in the egress strobe cycle minus the stored ingress time, taken modulo 2^TS_W, so a timebase wrap between the two events still gives the true elapsed count.
- R3: The value of `calib_ns` present in the egress strobe cycle is added, as an unsigned number, to every measured residence time.
- R4: For a known tag, `upd_corr` equals `egr_corr_in` (signed two's complement) plus (residence + calibration) × 65536. Negative incoming fields are corrected the same way.
- R5: If that sum exceeds 0x7FFF_FFFF_FFFF_FFFF, `upd_corr` is 0x7FFF_FFFF_FFFF_FFFF. The result never wraps to a negative value.
- R6: An egress strobe whose tag has no pending ingress time gives `upd_miss`=1 and `upd_corr` equal to `egr_corr_in`. For a known tag, `upd_miss`=0.
- R7: A successful egress releases the tag's entry, so a second egress with the same tag and no new ingress is reported as a miss.
- R8: Up to 2^TAG_W tags are pending at once, each with its own time. They can leave in any order.
- R9: `upd_valid` is 1 exactly in the cycle after an egress strobe, and `upd_tag` repeats that strobe's tag. An ingress strobe alone produces no result.
- R10: Synchronous active-high reset clears every pending entry and drops `upd_valid`.
- R11: An ingress strobe for a tag that is already pending replaces the stored time with the new one.
- R12: When ingress and egress strobes name the same tag in one cycle, the egress uses the time stored before that cycle, and the entry stays pending with the new ingress time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_ns | input | TS_W | Free-running nanosecond timebase |
| calib_ns | input | CAL_W | Fixed ingress-plus-egress latency term, in ns |
| ing_valid | input | 1 | Ingress event strobe |
| ing_tag | input | TAG_W | Packet tag at ingress |
| egr_valid | input | 1 | Egress event strobe |
| egr_tag | input | TAG_W | Packet tag at egress |
| egr_corr_in | input | 64 | Incoming correction field (signed, ns × 2^16) |
| upd_valid | output | 1 | Updated correction field is valid |
| upd_tag | output | TAG_W | Tag of the updated packet |
| upd_corr | output | 64 | Outgoing correction field |
| upd_miss | output | 1 | Egress tag had no pending ingress time |

## Verification
The bench builds the block with an 8-bit timebase, an 8-bit calibration term and a 2-bit tag, so that four entries are pending at most. With these values every residence count from 0 to 255 can be swept, with ingress times chosen so that many pairs straddle the timebase wrap. The calibration term takes a different value in each step, and incoming fields of both signs are used. The small table also makes it practical to fill every entry, to reuse and overwrite tags, and to drive saturation with a correction field near its positive limit.

// File: rtl/tcr_pkg.sv
package tcr_pkg;

    localparam int CORR_W = 64;
    localparam int FRAC_W = 16;

    typedef logic [CORR_W-1:0] corr_t;

    localparam corr_t CORR_MAX = {1'b0, {(CORR_W-1){1'b1}}};

    typedef struct packed {
        logic  miss;
        corr_t corr;
    } upd_t;

    // Signed base plus a non-negative increment, clamped at the positive limit.
    function automatic corr_t corr_sat_add(corr_t base, corr_t inc);
        logic [CORR_W:0] wide;
        wide = {base[CORR_W-1], base} + {1'b0, inc};
        if (!wide[CORR_W] && wide[CORR_W-1]) begin
            return CORR_MAX;
        end
        return wide[CORR_W-1:0];
    endfunction

endpackage

// File: rtl/tcr_tag_table.sv
module tcr_tag_table #(
    parameter int TAG_W = 3,
    parameter int TS_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TS_W-1:0]  wr_ts,
    input  logic             rd_en,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [TS_W-1:0]  rd_ts
);
    localparam int DEPTH = 1 << TAG_W;

    logic [DEPTH-1:0]           vld_q;
    logic [DEPTH-1:0][TS_W-1:0] ts_q;

    assign rd_hit = vld_q[rd_tag];
    assign rd_ts  = ts_q[rd_tag];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            ts_q  <= '0;
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (wr_en && wr_tag == TAG_W'(e)) begin
                    vld_q[e] <= 1'b1;
                    ts_q[e]  <= wr_ts;
                end else if (rd_en && rd_tag == TAG_W'(e)) begin
                    vld_q[e] <= 1'b0;
                end
            end
        end
    end

    AST_ENTRY_CAPTURED: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (vld_q[$past(wr_tag)] && ts_q[$past(wr_tag)] == $past(wr_ts))); // R1

    AST_ENTRY_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_hit && !(wr_en && wr_tag == rd_tag)) |=> !vld_q[$past(rd_tag)]); // R7

endmodule

// File: rtl/tcr_residence_calc.sv
module tcr_residence_calc
    import tcr_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int CAL_W = 16
) (
    input  logic [TS_W-1:0]  t_egress,
    input  logic [TS_W-1:0]  t_ingress,
    input  logic [CAL_W-1:0] calib,
    output corr_t            scaled
);
    localparam int SUM_W = ((TS_W > CAL_W) ? TS_W : CAL_W) + 1;

    logic [TS_W-1:0]  elapsed;
    logic [SUM_W-1:0] total;

    always_comb begin
        elapsed = t_egress - t_ingress;
        total   = SUM_W'(elapsed) + SUM_W'(calib);
        scaled  = CORR_W'(total) << FRAC_W;
    end

endmodule

// File: rtl/tc_residence_corrector.sv
module tc_residence_corrector
    import tcr_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int CAL_W = 16,
    parameter int TAG_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TS_W-1:0]   time_ns,
    input  logic [CAL_W-1:0]  calib_ns,
    input  logic              ing_valid,
    input  logic [TAG_W-1:0]  ing_tag,
    input  logic              egr_valid,
    input  logic [TAG_W-1:0]  egr_tag,
    input  logic [63:0]       egr_corr_in,
    output logic              upd_valid,
    output logic [TAG_W-1:0]  upd_tag,
    output logic [63:0]       upd_corr,
    output logic              upd_miss
);
    logic            tab_hit;
    logic [TS_W-1:0] tab_ts;
    corr_t           res_scaled;
    upd_t            upd_d, upd_q;
    logic            vld_q;
    logic [TAG_W-1:0] tag_q;

    tcr_tag_table #(.TAG_W(TAG_W), .TS_W(TS_W)) u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ing_valid),
        .wr_tag (ing_tag),
        .wr_ts  (time_ns),
        .rd_en  (egr_valid),
        .rd_tag (egr_tag),
        .rd_hit (tab_hit),
        .rd_ts  (tab_ts)
    );

    tcr_residence_calc #(.TS_W(TS_W), .CAL_W(CAL_W)) u_calc (
        .t_egress  (time_ns),
        .t_ingress (tab_ts),
        .calib     (calib_ns),
        .scaled    (res_scaled)
    );

    always_comb begin
        upd_d.miss = !tab_hit;
        upd_d.corr = tab_hit ? corr_sat_add(egr_corr_in, res_scaled) : egr_corr_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            tag_q <= '0;
            upd_q <= '0;
        end else begin
            vld_q <= egr_valid;
            if (egr_valid) begin
                tag_q <= egr_tag;
                upd_q <= upd_d;
            end
        end
    end

    assign upd_valid = vld_q;
    assign upd_tag   = tag_q;
    assign upd_corr  = upd_q.corr;
    assign upd_miss  = upd_q.miss;

    AST_UPD_FOLLOWS_EGR: assert property (@(posedge clk) disable iff (rst)
        egr_valid |=> (upd_valid && upd_tag == $past(egr_tag))); // R9

    AST_NO_SPURIOUS_UPD: assert property (@(posedge clk) disable iff (rst)
        !egr_valid |=> !upd_valid); // R9

    AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (egr_valid && !tab_hit) |=> (upd_miss && upd_corr == $past(egr_corr_in))); // R6

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (egr_valid && tab_hit) |=> $signed(upd_corr) >= $signed($past(egr_corr_in))); // R5

endmodule

// File: tb/tc_residence_corrector_test.sv
`timescale 1ns/1ps
module tc_residence_corrector_test;

    localparam int TS_W  = 8;
    localparam int CAL_W = 8;
    localparam int TAG_W = 2;
    localparam logic [63:0] MAXV = 64'h7FFF_FFFF_FFFF_FFFF;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [TS_W-1:0]   time_ns = '0;
    logic [CAL_W-1:0]  calib_ns = '0;
    logic              ing_valid = 1'b0;
    logic [TAG_W-1:0]  ing_tag = '0;
    logic              egr_valid = 1'b0;
    logic [TAG_W-1:0]  egr_tag = '0;
    logic [63:0]       egr_corr_in = '0;
    logic              upd_valid;
    logic [TAG_W-1:0]  upd_tag;
    logic [63:0]       upd_corr;
    logic              upd_miss;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    tc_residence_corrector #(.TS_W(TS_W), .CAL_W(CAL_W), .TAG_W(TAG_W)) uut (
        .clk(clk), .rst(rst), .time_ns(time_ns), .calib_ns(calib_ns),
        .ing_valid(ing_valid), .ing_tag(ing_tag),
        .egr_valid(egr_valid), .egr_tag(egr_tag), .egr_corr_in(egr_corr_in),
        .upd_valid(upd_valid), .upd_tag(upd_tag), .upd_corr(upd_corr), .upd_miss(upd_miss)
    );

    function automatic logic [63:0] expect_corr(int ti, int te, int cal, logic [63:0] cin);
        logic signed [71:0] sum;
        int res;
        res = ((te - ti) % 256 + 256) % 256 + cal;
        sum = $signed({{8{cin[63]}}, cin}) + 72'(res) * 72'd65536;
        if (sum > $signed({8'd0, MAXV})) return MAXV;
        return sum[63:0];
    endfunction

    // One clock: drive at the falling edge, then clear strobes at the next one.
    task automatic cyc(input logic iv, input int itag, input logic ev, input int etag,
                       input int t, input int cal, input logic [63:0] cin);
        @(negedge clk);
        ing_valid   = iv;
        ing_tag     = TAG_W'(itag);
        egr_valid   = ev;
        egr_tag     = TAG_W'(etag);
        time_ns     = TS_W'(t);
        calib_ns    = CAL_W'(cal);
        egr_corr_in = cin;
        @(negedge clk);
        ing_valid = 1'b0;
        egr_valid = 1'b0;
    endtask

    task automatic chk(input string req, input logic ev, input logic emiss,
                       input logic [63:0] ecorr, input int etag);
        checks++;
        if (upd_valid !== ev ||
            (ev && (upd_miss !== emiss || upd_corr !== ecorr || upd_tag !== TAG_W'(etag)))) begin
            failures++;
            $display("FAIL %s: got valid=%b miss=%b corr=%h tag=%0d, expected valid=%b miss=%b corr=%h tag=%0d",
                     req, upd_valid, upd_miss, upd_corr, upd_tag, ev, emiss, ecorr, etag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset output", 1'b0, 1'b0, 64'd0, 0);

        // R10 / R6: nothing pending after reset
        cyc(0, 0, 1, 0, 7, 3, 64'h1234);
        chk("R6 R10 miss after reset", 1'b1, 1'b1, 64'h1234, 0);
        @(negedge clk);
        chk("R9 valid drops", 1'b0, 1'b0, 64'd0, 0);

        // R9: ingress alone yields no result
        cyc(1, 2, 0, 0, 10, 0, 64'd0);
        chk("R9 ingress only", 1'b0, 1'b0, 64'd0, 0);

        // R8: four outstanding tags, out of order
        cyc(1, 0, 0, 0, 10, 0, 0);
        cyc(1, 1, 0, 0, 20, 0, 0);
        cyc(1, 2, 0, 0, 30, 0, 0);
        cyc(1, 3, 0, 0, 40, 0, 0);
        cyc(0, 0, 1, 3, 100, 5, 64'd0);
        chk("R8 tag3", 1'b1, 1'b0, expect_corr(40, 100, 5, 0), 3);
        cyc(0, 0, 1, 1, 101, 5, 64'd0);
        chk("R8 tag1", 1'b1, 1'b0, expect_corr(20, 101, 5, 0), 1);
        cyc(0, 0, 1, 0, 102, 0, -64'sd1000000);
        chk("R4 R8 tag0 negative field", 1'b1, 1'b0, expect_corr(10, 102, 0, -64'sd1000000), 0);
        cyc(0, 0, 1, 2, 250, 9, 64'd77);
        chk("R8 tag2", 1'b1, 1'b0, expect_corr(30, 250, 9, 64'd77), 2);

        // R7: entry released
        cyc(0, 0, 1, 3, 120, 5, 64'hABCD);
        chk("R7 second egress misses", 1'b1, 1'b1, 64'hABCD, 3);

        // R5: saturation
        cyc(1, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 1, 200, 255, MAXV - 64'd1000);
        chk("R5 saturate", 1'b1, 1'b0, MAXV, 1);
        cyc(1, 1, 0, 0, 33, 0, 0);
        cyc(0, 0, 1, 1, 33, 0, MAXV);
        chk("R5 zero residence at max", 1'b1, 1'b0, MAXV, 1);

        // R11: overwrite pending time
        cyc(1, 2, 0, 0, 5, 0, 0);
        cyc(1, 2, 0, 0, 50, 0, 0);
        cyc(0, 0, 1, 2, 60, 0, 64'd0);
        chk("R11 overwrite", 1'b1, 1'b0, 64'd10 << 16, 2);

        // R12: same-cycle ingress and egress on one tag
        cyc(1, 0, 0, 0, 70, 0, 0);
        cyc(1, 0, 1, 0, 90, 0, 64'd0);
        chk("R12 egress uses old time", 1'b1, 1'b0, 64'd20 << 16, 0);
        cyc(0, 0, 1, 0, 95, 0, 64'd0);
        chk("R12 new entry kept", 1'b1, 1'b0, 64'd5 << 16, 0);

        // R1 R2 R3 R4: sweep every residence count, with wrap and varied calibration
        for (int d = 0; d < 256; d++) begin
            int ti, te, cal, tg;
            logic [63:0] cin;
            tg  = d % 4;
            ti  = (d * 37 + 200) % 256;
            te  = (ti + d) % 256;
            cal = (d * 11) % 256;
            cin = 64'(d * 123457) - 64'd9000000;
            cyc(1, tg, 0, 0, ti, 0, 0);
            cyc(0, 0, 1, tg, te, cal, cin);
            chk("R1 R2 R3 R4 sweep", 1'b1, 1'b0, expect_corr(ti, te, cal, cin), tg);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule